// File: doc/BRIEF.md
# Multi-Engine Reset Handshake Sequencer

This controller coordinates a guarded reset of several execution engines. Before anything is reset, each engine affected receives a request and must confirm through a ready input that it has reached a safe point. Each wait for a confirmation has a bound. A wait that runs out withdraws the outstanding requests.

A start command selects one of two paths. The single-engine path requests one engine and resets that engine alone once it confirms. If it does not confirm in time, the job is promoted to the full path. The full path requests the engines one at a time, in ascending index order. It waits for each engine to confirm before requesting the next one, and pulses the global reset only after every engine has confirmed. A failed round of the full path is retried a bounded number of times. After the last retry fails, a parameter decides the outcome: the global reset is either forced anyway or abandoned with an error status.

Top module: `rstseq_ctrl`

## Requirements
- R1: A start is accepted only while `busy_o` is low and, in single mode, only if `eng_sel_i` is below NUM_ENG; otherwise it has no effect. `busy_o` rises in the cycle after acceptance and stays high through the cycle in which `done_o` is high. A start while busy changes nothing in the running job.
- R2: Single mode (`mode_i`=0) raises only `req_o[sel]`. When `rdy_i[sel]` is seen, `eng_rst_o[sel]` pulses for one cycle with the request still high. The next cycle has `done_o` high, all requests low and status CLEAN (0). No global reset is issued.
- R3: A ready wait that sees the engine ready in its L-th cycle (counting from 0, L < WAIT_TICKS) lasts L+1 cycles. A wait that never sees ready lasts exactly WAIT_TICKS cycles.
- R4: When a wait expires, all request bits go low in the next cycle. Before a retry or a promotion they stay low for exactly one cycle, and only then is engine 0 requested again.
- R5: When a single-mode wait expires, the job continues on the full path. If the full path then succeeds, the final status is ESCALATED (1) and no engine-only reset pulse is given.
- R6: Full mode (`mode_i`=1) requests engine 0 first. Each time the engine in turn confirms, the next request bit is set and earlier bits stay set, so `req_o` is always a contiguous run of ones from bit 0. One cycle after the last engine confirms, `glb_rst_o` pulses with all requests high, and the status is CLEAN (0) unless the job was promoted.
- R7: A failed full round is re-run from engine 0. At most RETRY_LIMIT re-runs follow the first round.
- R8: When the final round fails, the outcome depends on FORCE_ON_GIVEUP. With the value 1, `glb_rst_o` pulses in the next cycle with all requests low, and the status is FORCED (2). With the value 0, no global reset is issued, and `done_o` follows in the next cycle with status ABORTED (3).
- R9: Every `glb_rst_o` or `eng_rst_o` pulse lasts one cycle and is followed at once by a one-cycle `done_o` with all requests low. `status_o` keeps its value until the next job completes. In the cycle after `done_o`, `busy_o` is low.
- R10: After reset, `busy_o`, `done_o`, `glb_rst_o`, `req_o` and `eng_rst_o` are all low, and `status_o` is CLEAN (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled while idle |
| mode_i | input | 1 | 0 = single-engine path, 1 = full path |
| eng_sel_i | input | IDXW | Engine index for the single-engine path |
| rdy_i | input | NUM_ENG | Per-engine ready-to-reset confirmation |
| req_o | output | NUM_ENG | Per-engine reset request |
| eng_rst_o | output | NUM_ENG | One-cycle reset pulse for a single engine |
| glb_rst_o | output | 1 | One-cycle global reset pulse |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion |
| status_o | output | 2 | 0 clean, 1 escalated, 2 forced, 3 aborted |

## Verification
The bench builds two instances with three engines, a six-cycle wait bound and two retries. One instance forces the global reset on give-up and the other abandons it. Engine models answer with a latency equal to their index and ignore a chosen number of requests before they confirm. With these values, every failure count from zero to three on every engine can be swept, which covers success on the first round, success on each retry, and exhaustion. Both modes and both give-up policies are run, and the out-of-range index value 3 is reachable on the two-bit select.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN     = 2'd0,
      ST_ESCALATED = 2'd1,
      ST_FORCED    = 2'd2,
      ST_ABORTED   = 2'd3
   } rs_status_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ONE_WAIT,
      PH_ONE_RST,
      PH_BACKOFF,
      PH_ALL_WAIT,
      PH_GLOBAL,
      PH_FINISH
   } rs_phase_e;

   localparam logic MODE_SINGLE = 1'b0;
   localparam logic MODE_ALL    = 1'b1;

endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
   parameter int unsigned TICKS = 700,
   localparam int unsigned CW   = (TICKS > 1) ? $clog2(TICKS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);

   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run_i)          cnt_q <= '0;
      else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/rstseq_retry.sv
module rstseq_retry #(
   parameter int unsigned LIMIT = 3,
   localparam int unsigned RW   = $clog2(LIMIT + 1) > 0 ? $clog2(LIMIT + 1) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic exhausted_o
);

   localparam logic [RW-1:0] TOP = RW'(LIMIT);

   logic [RW-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      used_q <= '0;
      else if (clr_i)                  used_q <= '0;
      else if (inc_i && used_q != TOP) used_q <= used_q + 1'b1;
   end

   assign exhausted_o = (used_q == TOP);

endmodule

// File: rtl/rstseq_reqbank.sv
module rstseq_reqbank #(
   parameter int unsigned NUM_ENG = 4,
   parameter int unsigned IDXW    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en_i,
   input  logic [IDXW-1:0]    set_idx_i,
   input  logic               clr_all_i,
   input  logic [IDXW-1:0]    cur_idx_i,
   input  logic               pulse_i,
   input  logic [NUM_ENG-1:0] rdy_i,
   output logic [NUM_ENG-1:0] req_o,
   output logic [NUM_ENG-1:0] eng_rst_o,
   output logic               rdy_sel_o
);

   genvar k;
   generate
      for (k = 0; k < NUM_ENG; k++) begin : g_eng
         localparam logic [IDXW-1:0] KID = IDXW'(k);
         logic bit_q;

         // only the addressed bit is touched by a set; others keep their value
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             bit_q <= 1'b0;
            else if (clr_all_i)                     bit_q <= 1'b0;
            else if (set_en_i && set_idx_i == KID)  bit_q <= 1'b1;
         end

         assign req_o[k]     = bit_q;
         assign eng_rst_o[k] = pulse_i && (cur_idx_i == KID);
      end
   endgenerate

   always_comb begin
      rdy_sel_o = 1'b0;
      for (int j = 0; j < NUM_ENG; j++) begin
         if (cur_idx_i == IDXW'(j)) rdy_sel_o = rdy_i[j];
      end
   end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int unsigned NUM_ENG         = 4,
   parameter int unsigned WAIT_TICKS      = 700,
   parameter int unsigned RETRY_LIMIT     = 3,
   parameter bit          FORCE_ON_GIVEUP = 1'b1,
   localparam int unsigned IDXW           = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               mode_i,
   input  logic [IDXW-1:0]    eng_sel_i,
   input  logic [NUM_ENG-1:0] rdy_i,
   output logic [NUM_ENG-1:0] req_o,
   output logic [NUM_ENG-1:0] eng_rst_o,
   output logic               glb_rst_o,
   output logic               busy_o,
   output logic               done_o,
   output logic [1:0]         status_o
);

   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_ENG - 1);

   generate
      if (NUM_ENG < 1) begin : g_bad_eng
         $error("rstseq_ctrl: NUM_ENG must be at least 1");
      end
      if (WAIT_TICKS < 1) begin : g_bad_wait
         $error("rstseq_ctrl: WAIT_TICKS must be at least 1");
      end
   endgenerate

   rs_phase_e       phase_q, phase_d;
   logic [IDXW-1:0] idx_q, idx_d;
   logic            esc_q, esc_d;
   rs_status_e      stat_q, stat_d;

   logic            set_en, clr_all;
   logic [IDXW-1:0] set_idx;
   logic            retry_clr, retry_inc, exhausted;
   logic            rdy_sel, expire, waiting;
   logic            sel_ok;

   rs_phase_e       giveup_phase;
   rs_status_e      giveup_stat;

   // policy applied once the last permitted round has failed
   generate
      if (FORCE_ON_GIVEUP) begin : g_force
         assign giveup_phase = PH_GLOBAL;
         assign giveup_stat  = ST_FORCED;
      end else begin : g_abort
         assign giveup_phase = PH_FINISH;
         assign giveup_stat  = ST_ABORTED;
      end
   endgenerate

   assign sel_ok  = (int'(eng_sel_i) < int'(NUM_ENG));
   assign waiting = (phase_q == PH_ONE_WAIT) || (phase_q == PH_ALL_WAIT);

   rstseq_timer #(.TICKS(WAIT_TICKS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (waiting && !rdy_sel),
      .expire_o (expire)
   );

   rstseq_retry #(.LIMIT(RETRY_LIMIT)) u_retry (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (retry_clr),
      .inc_i       (retry_inc),
      .exhausted_o (exhausted)
   );

   rstseq_reqbank #(.NUM_ENG(NUM_ENG), .IDXW(IDXW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en_i  (set_en),
      .set_idx_i (set_idx),
      .clr_all_i (clr_all),
      .cur_idx_i (idx_q),
      .pulse_i   (phase_q == PH_ONE_RST),
      .rdy_i     (rdy_i),
      .req_o     (req_o),
      .eng_rst_o (eng_rst_o),
      .rdy_sel_o (rdy_sel)
   );

   always_comb begin
      phase_d   = phase_q;
      idx_d     = idx_q;
      esc_d     = esc_q;
      stat_d    = stat_q;
      set_en    = 1'b0;
      set_idx   = idx_q;
      clr_all   = 1'b0;
      retry_clr = 1'b0;
      retry_inc = 1'b0;

      unique case (phase_q)
         PH_IDLE: begin
            if (start_i) begin
               if (mode_i == MODE_SINGLE) begin
                  if (sel_ok) begin
                     retry_clr = 1'b1;
                     esc_d     = 1'b0;
                     idx_d     = eng_sel_i;
                     set_en    = 1'b1;
                     set_idx   = eng_sel_i;
                     phase_d   = PH_ONE_WAIT;
                  end
               end else begin
                  retry_clr = 1'b1;
                  esc_d     = 1'b0;
                  idx_d     = '0;
                  set_en    = 1'b1;
                  set_idx   = '0;
                  phase_d   = PH_ALL_WAIT;
               end
            end
         end

         PH_ONE_WAIT: begin
            if (rdy_sel) begin
               phase_d = PH_ONE_RST;
            end else if (expire) begin
               clr_all = 1'b1;
               esc_d   = 1'b1;
               phase_d = PH_BACKOFF;
            end
         end

         PH_ONE_RST: begin
            clr_all = 1'b1;
            stat_d  = ST_CLEAN;
            phase_d = PH_FINISH;
         end

         PH_BACKOFF: begin
            idx_d   = '0;
            set_en  = 1'b1;
            set_idx = '0;
            phase_d = PH_ALL_WAIT;
         end

         PH_ALL_WAIT: begin
            if (rdy_sel) begin
               if (idx_q == LAST_IDX) begin
                  phase_d = PH_GLOBAL;
                  stat_d  = esc_q ? ST_ESCALATED : ST_CLEAN;
               end else begin
                  idx_d   = idx_q + 1'b1;
                  set_en  = 1'b1;
                  set_idx = idx_q + 1'b1;
               end
            end else if (expire) begin
               clr_all = 1'b1;
               if (exhausted) begin
                  phase_d = giveup_phase;
                  stat_d  = giveup_stat;
               end else begin
                  retry_inc = 1'b1;
                  phase_d   = PH_BACKOFF;
               end
            end
         end

         PH_GLOBAL: begin
            clr_all = 1'b1;
            phase_d = PH_FINISH;
         end

         PH_FINISH: begin
            phase_d = PH_IDLE;
         end

         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         esc_q   <= 1'b0;
         stat_q  <= ST_CLEAN;
      end else begin
         phase_q <= phase_d;
         idx_q   <= idx_d;
         esc_q   <= esc_d;
         stat_q  <= stat_d;
      end
   end

   assign glb_rst_o = (phase_q == PH_GLOBAL);
   assign done_o    = (phase_q == PH_FINISH);
   assign busy_o    = (phase_q != PH_IDLE);
   assign status_o  = stat_q;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
   parameter int unsigned NUM_ENG = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_ENG-1:0] req_o,
   input logic [NUM_ENG-1:0] eng_rst_o,
   input logic               glb_rst_o,
   input logic               busy_o,
   input logic               done_o,
   input logic [1:0]         status_o
);

   localparam logic [NUM_ENG-1:0] ALL_REQ = '1;

   AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o); // R1

   AST_ENG_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eng_rst_o)); // R2

   AST_ENG_RST_NO_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      (|eng_rst_o) |-> (!glb_rst_o && (req_o & eng_rst_o) == eng_rst_o)); // R2

   AST_ENG_RST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (|eng_rst_o) |=> (done_o && req_o == '0 && status_o == 2'd0)); // R2

   AST_REQ_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_o & ~$past(req_o)) <= 1); // R6

   AST_CLEAN_GLOBAL_ALL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_rst_o && status_o != 2'd2) |-> (req_o == ALL_REQ)); // R6

   AST_FORCED_GLOBAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_rst_o && status_o == 2'd2) |-> (req_o == '0)); // R8

   AST_GLOBAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      glb_rst_o |=> !glb_rst_o); // R9

   AST_GLOBAL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      glb_rst_o |=> (done_o && req_o == '0)); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o)); // R9

   AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> $stable(status_o)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (req_o == '0 && !glb_rst_o && eng_rst_o == '0)); // R10

endmodule

bind rstseq_ctrl rstseq_chk #(.NUM_ENG(NUM_ENG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_o     (req_o),
   .eng_rst_o (eng_rst_o),
   .glb_rst_o (glb_rst_o),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .status_o  (status_o)
);

// File: tb/tb_rstseq_ctrl.sv
`timescale 1ns/1ps

module tb_eng_model (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] fail_in,
   input  logic [1:0] lat,
   input  logic       req,
   output logic       rdy
);
   logic       prev, stuck;
   logic [3:0] age;
   logic [1:0] fails;
   logic       rising;

   assign rising = req && !prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0; stuck <= 1'b0; age <= '0; fails <= '0;
      end else begin
         if (load) fails <= fail_in;
         prev <= req;
         if (rising) begin
            age   <= 4'd1;
            stuck <= (fails != 2'd0);
            if (fails != 2'd0) fails <= fails - 2'd1;
         end else if (req && age != 4'd15) begin
            age <= age + 4'd1;
         end
      end
   end

   assign rdy = req && (rising ? (fails == 2'd0 && lat == 2'd0)
                               : (!stuck && age >= {2'b00, lat}));
endmodule

module tb_rstseq_ctrl;
   localparam int NE = 3;
   localparam int T  = 6;
   localparam int RL = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       start_a = 1'b0, start_b = 1'b0, mode = 1'b0, load = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [1:0] fail_v [NE];

   logic [NE-1:0] req_a, rdy_a, er_a, req_b, rdy_b, er_b;
   logic          gl_a, busy_a, done_a, gl_b, busy_b, done_b;
   logic [1:0]    st_a, st_b;

   rstseq_ctrl #(.NUM_ENG(NE), .WAIT_TICKS(T), .RETRY_LIMIT(RL), .FORCE_ON_GIVEUP(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_a), .mode_i(mode), .eng_sel_i(sel),
      .rdy_i(rdy_a), .req_o(req_a), .eng_rst_o(er_a), .glb_rst_o(gl_a),
      .busy_o(busy_a), .done_o(done_a), .status_o(st_a));

   rstseq_ctrl #(.NUM_ENG(NE), .WAIT_TICKS(T), .RETRY_LIMIT(RL), .FORCE_ON_GIVEUP(1'b0)) dut_abort (
      .clk(clk), .rst_n(rst_n), .start_i(start_b), .mode_i(mode), .eng_sel_i(sel),
      .rdy_i(rdy_b), .req_o(req_b), .eng_rst_o(er_b), .glb_rst_o(gl_b),
      .busy_o(busy_b), .done_o(done_b), .status_o(st_b));

   for (genvar k = 0; k < NE; k++) begin : g_m
      tb_eng_model u_a (.clk(clk), .rst_n(rst_n), .load(load), .fail_in(fail_v[k]),
                        .lat(2'(k)), .req(req_a[k]), .rdy(rdy_a[k]));
      tb_eng_model u_b (.clk(clk), .rst_n(rst_n), .load(load), .fail_in(fail_v[k]),
                        .lat(2'(k)), .req(req_b[k]), .rdy(rdy_b[k]));
   end

   logic          use_b = 1'b0;
   logic [NE-1:0] c_req, c_er;
   logic          c_gl, c_busy, c_done;
   logic [1:0]    c_st;
   assign c_req  = use_b ? req_b  : req_a;
   assign c_er   = use_b ? er_b   : er_a;
   assign c_gl   = use_b ? gl_b   : gl_a;
   assign c_busy = use_b ? busy_b : busy_a;
   assign c_done = use_b ? done_b : done_a;
   assign c_st   = use_b ? st_b   : st_a;

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_start(input bit v);
      if (use_b) start_b = v; else start_a = v;
   endtask

   task automatic run_case(input bit which, input bit md, input int s,
                           input int fa, input int fb, input int fc);
      int fl[NE];
      int d, bo, st, glob, eng, zero, n, n_gl, n_er, n_zero;
      bit esc, fin, ok, pat_ok;
      string tag;
      fl[0] = fa; fl[1] = fb; fl[2] = fc;
      d = 0; bo = 0; st = 0; glob = 0; eng = 0; zero = 0; esc = 0; fin = 0;
      tag = "R6";
      if (!md) begin
         if (fl[s] > 0) begin
            fl[s]--; d += T + 1; bo++; esc = 1; tag = "R5";
         end else begin
            d = s + 2; eng = 1; zero = 1; fin = 1; tag = "R2";
         end
      end
      if (!fin) begin
         for (int r = 0; r <= RL && !fin; r++) begin
            ok = 1;
            for (int k = 0; k < NE && ok; k++) begin
               if (fl[k] > 0) begin fl[k]--; d += T; ok = 0; end
               else d += k + 1;
            end
            if (ok) begin
               d += 1; st = esc ? 1 : 0; glob = 1; zero = bo + 1; fin = 1;
               if (!esc && bo > 0) tag = "R7";
            end else if (r < RL) begin
               d += 1; bo++;
            end
         end
         if (!fin) begin
            tag = "R8";
            if (!which) begin d += 1; glob = 1; st = 2; zero = bo + 2; end
            else begin st = 3; zero = bo + 1; end
         end
      end

      use_b = which;
      @(negedge clk);
      fail_v[0] = 2'(fa); fail_v[1] = 2'(fb); fail_v[2] = 2'(fc);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      mode = md; sel = 2'(s);
      set_start(1'b1);
      @(posedge clk);
      @(negedge clk);
      set_start(1'b0);
      n = 0; n_gl = 0; n_er = 0; n_zero = 0; pat_ok = 1;
      while (n < 500) begin
         if (c_gl) n_gl++;
         if (c_er != '0) n_er++;
         if (c_req == '0) n_zero++;
         if (!(c_req == '0 || c_req == 3'b001 || c_req == 3'b011 || c_req == 3'b111 ||
               (!md && c_req == (3'b001 << s))))
            pat_ok = 0;
         if (!c_busy) pat_ok = 0;
         if (c_done) break;
         if (n == 2) begin mode = ~md; sel = 2'd0; set_start(1'b1); end
         @(posedge clk);
         n++;
         @(negedge clk);
         set_start(1'b0); mode = md;
      end
      set_start(1'b0);
      chk(n == d, $sformatf("R3 %s cycles to done", tag), n, d);
      chk(int'(c_st) == st, $sformatf("%s status", tag), int'(c_st), st);
      chk(n_gl == glob, $sformatf("%s global pulses", tag), n_gl, glob);
      chk(n_er == eng, "R2 engine pulses", n_er, eng);
      chk(n_zero == zero, "R4 request-low cycles", n_zero, zero);
      chk(pat_ok, "R6 request pattern and R1 busy", int'(pat_ok), 1);
      @(posedge clk);
      @(negedge clk);
      chk(!c_busy && c_req == '0 && !c_done, "R9 idle after done", int'(c_busy), 0);
      chk(int'(c_st) == st, "R9 status held", int'(c_st), st);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      fail_v[0] = '0; fail_v[1] = '0; fail_v[2] = '0;
      repeat (3) @(negedge clk);
      // R10 reset state, checked while reset is held and after release
      chk(!busy_a && !done_a && !gl_a && req_a == '0 && er_a == '0 && st_a == 2'd0,
          "R10 reset state force", int'(busy_a), 0);
      chk(!busy_b && !done_b && !gl_b && req_b == '0 && er_b == '0 && st_b == 2'd0,
          "R10 reset state abort", int'(busy_b), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_a && req_a == '0 && st_a == 2'd0, "R10 after release", int'(req_a), 0);

      // R1 out-of-range engine index is ignored
      use_b = 1'b0; mode = 1'b0; sel = 2'd3; start_a = 1'b1;
      @(posedge clk); @(negedge clk); start_a = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(!busy_a && req_a == '0, "R1 out-of-range start ignored", int'(busy_a), 0);
         @(negedge clk);
      end

      for (int w = 0; w < 2; w++) begin
         for (int fa = 0; fa < 4; fa++)
            for (int fb = 0; fb < 4; fb++)
               for (int fc = 0; fc < 4; fc++)
                  run_case(w[0], 1'b1, 0, fa, fb, fc);
         for (int s = 0; s < NE; s++)
            for (int fs = 0; fs < 4; fs++)
               for (int fo = 0; fo < 2; fo++)
                  run_case(w[0], 1'b0, s, (s == 0) ? fs : fo,
                           (s == 1) ? fs : fo, (s == 2) ? fs : fo);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule